// File: doc/BRIEF.md
# ADC Regular-Sequence Conversion Controller

This block is the digital control side of a successive-approximation ADC. Software uses a small register port to power the converter, pick a resolution and set a sampling time for each analog channel. It also programs an ordered list of up to 16 channel slots and then starts the list. The controller steps through the list. For each slot it holds the converter in a sampling phase and then in a conversion phase, and each phase lasts a fixed number of cycles.

At the end of each conversion the controller tells an abstract converter model to hand over its 12-bit sample. It right-aligns the sample to the chosen resolution, stores it in a 16-bit result register and raises a completion flag. In single mode the list runs once. In continuous mode it starts again from the first slot. When scanning is off, only the first slot is converted.

Top module: `adc_seq_top`

## Requirements
- R1: The resolution code `res` (CTRL bits 5:4) sets the conversion phase length: 00 → 15 cycles (12 bits), 01 → 13 (10 bits), 10 → 11 (8 bits), 11 → 9 (6 bits).
- R2: Each channel has a 3-bit sampling code that sets the sampling phase length: 0..7 → 3, 15, 28, 56, 84, 112, 144, 480 cycles. Channels 0-9 are in SMPLO (address 2) and channels 10-18 are in SMPHI (address 3), at bits 3k+2:3k for the k-th channel of each register. A channel outside 0..18 samples for 3 cycles. From the clock edge that takes a start write to the edge that sets the completion flag there are 1 + sample + conversion cycles.
- R3: Slots are 5-bit channel numbers. Slots 0-5 are in SEQA (address 4), slots 6-11 in SEQB (address 5) and slots 12-15 in SEQC (address 6), at bits 5j+4:5j. The length field, SEQC bits 23:20, gives 1 + value slots. With `scan` (CTRL bit 3) set, slots are converted in order from slot 0. With it clear, only slot 0 is converted. Single mode then goes idle.
- R4: With `cont` (CTRL bit 2) set, the sequence restarts at slot 0 after its last slot and continues without a further start.
- R5: While `en` (CTRL bit 0) is 0, a start write is ignored. Clearing `en` during a sequence stops it at once and no further result is produced.
- R6: Writing 1 to `start` (CTRL bit 1) begins the sequence. The bit reads back as 0 once the sequence has begun. A start written while a sequence runs is ignored. `busy` reads at STATUS bit 1 (address 0).
- R7: The completion flag (STATUS bit 0, also the `eocFlag` pin) becomes 1 at every finished conversion. It clears when software reads DATA (address 7) or writes 0 to STATUS bit 0. It is 0 after reset.
- R8: The result is the converter's 12-bit sample shifted right by 2·`res` and zero-extended to 16 bits. It appears on `dataOut` and is read at DATA.
- R9: After reset every register reads 0 and no conversion runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (side effect for DATA) |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` (combinational) |
| anaStart | output | 1 | One-cycle pulse on the first sampling cycle of a slot |
| anaLatch | output | 1 | High in the last conversion cycle, when `anaValue` is taken |
| anaChan | output | 5 | Channel of the current slot |
| anaValue | input | 12 | Sample delivered by the converter model |
| eocFlag | output | 1 | Completion flag |
| dataOut | output | 16 | Result register |

## Verification
A result is due one clock edge after the cycle in which `anaLatch` is high. The scoreboard monitor records `anaLatch` at a falling edge and compares `dataOut` and `eocFlag` at the next falling edge. The completion flag must appear exactly 1 + sample + conversion rising edges after the edge that took the start write, and the bench counts rising edges from that write for four resolution/sampling pairs. Checks on ignored starts and aborts wait longer than any slot could take, then compare the counts of `anaStart` and `anaLatch` pulses against the expected counts.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int CNT_W = 9;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic startAck;
    logic capture;
    logic busy;
  } ctlStrobe_t;

  // datapath -> control configuration
  typedef struct packed {
    logic       enable;
    logic       startReq;
    logic       continuous;
    logic       scan;
    logic [1:0] res;
    logic [3:0] seqLen;
  } cfg_t;

  function automatic logic [CNT_W-1:0] smpCycles(input logic [2:0] code);
    case (code)
      3'd0: return 9'd3;
      3'd1: return 9'd15;
      3'd2: return 9'd28;
      3'd3: return 9'd56;
      3'd4: return 9'd84;
      3'd5: return 9'd112;
      3'd6: return 9'd144;
      default: return 9'd480;
    endcase
  endfunction

  // 12-bit takes 15 cycles, each 2 bits fewer saves 2 cycles
  function automatic logic [CNT_W-1:0] convCycles(input logic [1:0] res);
    return 9'd15 - {6'd0, res, 1'b0};
  endfunction

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH    = 19,
  parameter int NUM_SLOTS = 16,
  parameter int CH_W      = 5,
  parameter int SMP_W     = 3,
  parameter int DATA_W    = 12,
  parameter int REG_W     = 16,
  parameter int BUS_W     = 32,
  parameter int ADDR_W    = 3,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]  regWdata,
  output logic [BUS_W-1:0]  regRdata,
  input  ctlStrobe_t        strb,
  input  logic [SLOT_W-1:0] slotIdx,
  input  logic [SLOT_W-1:0] nextIdx,
  input  logic [DATA_W-1:0] anaValue,
  output cfg_t              cfg,
  output logic [CH_W-1:0]   curChan,
  output logic [SMP_W-1:0]  nextSmp,
  output logic              eocFlag,
  output logic [REG_W-1:0]  dataOut
);

  localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
  localparam logic [ADDR_W-1:0] A_SMPLO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_SMPHI  = 3'd3;
  localparam logic [ADDR_W-1:0] A_SEQA   = 3'd4;
  localparam logic [ADDR_W-1:0] A_DATA   = 3'd7;

  localparam int SMP_PER_REG  = BUS_W / SMP_W;
  localparam int SLOT_PER_REG = BUS_W / CH_W;
  localparam int LEN_LSB      = (NUM_SLOTS - 2 * SLOT_PER_REG) * CH_W;

  logic [SMP_W-1:0] smpCode [NUM_CH];
  logic [CH_W-1:0]  slotChan [NUM_SLOTS];
  logic [BUS_W-1:0] smpLoRd, smpHiRd;
  logic [BUS_W-1:0] seqRd [3];

  // per-channel sampling codes
  for (genvar c = 0; c < NUM_CH; c++) begin : g_smp
    localparam logic [ADDR_W-1:0] MY_ADDR = (c < SMP_PER_REG) ? A_SMPLO : A_SMPHI;
    localparam int MY_LSB = (c % SMP_PER_REG) * SMP_W;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        smpCode[c] <= '0;
      else if (regWe && regAddr == MY_ADDR)
        smpCode[c] <= regWdata[MY_LSB +: SMP_W];
    end
  end

  // sequence slots
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam logic [ADDR_W-1:0] MY_ADDR = A_SEQA + ADDR_W'(s / SLOT_PER_REG);
    localparam int MY_LSB = (s % SLOT_PER_REG) * CH_W;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        slotChan[s] <= '0;
      else if (regWe && regAddr == MY_ADDR)
        slotChan[s] <= regWdata[MY_LSB +: CH_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cfg.seqLen <= '0;
    else if (regWe && regAddr == A_SEQA + 3'd2)
      cfg.seqLen <= regWdata[LEN_LSB +: 4];
  end

  // control word; start only accepted when powered and idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg.enable     <= 1'b0;
      cfg.startReq   <= 1'b0;
      cfg.continuous <= 1'b0;
      cfg.scan       <= 1'b0;
      cfg.res        <= 2'd0;
    end else begin
      if (regWe && regAddr == A_CTRL) begin
        cfg.enable     <= regWdata[0];
        cfg.continuous <= regWdata[2];
        cfg.scan       <= regWdata[3];
        cfg.res        <= regWdata[5:4];
      end
      if (strb.startAck)
        cfg.startReq <= 1'b0;
      else if (regWe && regAddr == A_CTRL)
        cfg.startReq <= regWdata[1] & regWdata[0] & ~strb.busy;
      else if (!cfg.enable)
        cfg.startReq <= 1'b0;
    end
  end

  // result and completion flag
  logic [DATA_W-1:0] aligned;
  assign aligned = anaValue >> {cfg.res, 1'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      eocFlag <= 1'b0;
    end else if (strb.capture) begin
      dataOut <= REG_W'(aligned);
      eocFlag <= 1'b1;
    end else if (regRe && regAddr == A_DATA) begin
      eocFlag <= 1'b0;
    end else if (regWe && regAddr == A_STATUS && !regWdata[0]) begin
      eocFlag <= 1'b0;
    end
  end

  // slot lookup for the controller
  logic [CH_W-1:0] nextChan;
  assign curChan  = slotChan[slotIdx];
  assign nextChan = slotChan[nextIdx];
  always_comb begin
    nextSmp = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (nextChan == CH_W'(c)) nextSmp = smpCode[c];
  end

  // readback
  always_comb begin
    smpLoRd = '0;
    smpHiRd = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (c < SMP_PER_REG) smpLoRd[(c % SMP_PER_REG) * SMP_W +: SMP_W] = smpCode[c];
      else                 smpHiRd[(c % SMP_PER_REG) * SMP_W +: SMP_W] = smpCode[c];
    end
    for (int r = 0; r < 3; r++) seqRd[r] = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      seqRd[s / SLOT_PER_REG][(s % SLOT_PER_REG) * CH_W +: CH_W] = slotChan[s];
    seqRd[2][LEN_LSB +: 4] = cfg.seqLen;
  end

  always_comb begin
    case (regAddr)
      A_STATUS: regRdata = {{(BUS_W-2){1'b0}}, strb.busy, eocFlag};
      A_CTRL:   regRdata = {{(BUS_W-6){1'b0}}, cfg.res, cfg.scan, cfg.continuous,
                            cfg.startReq, cfg.enable};
      A_SMPLO:  regRdata = smpLoRd;
      A_SMPHI:  regRdata = smpHiRd;
      3'd4:     regRdata = seqRd[0];
      3'd5:     regRdata = seqRd[1];
      3'd6:     regRdata = seqRd[2];
      default:  regRdata = {{(BUS_W-REG_W){1'b0}}, dataOut};
    endcase
  end

  // R6: start request consumed as the sequence begins
  a_r6_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.startAck |=> !cfg.startReq);

  // R7: completion flag follows every capture
  a_r7_eoc_set: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> eocFlag);

  // R8: at 6-bit resolution upper result bits are zero
  a_r8_six_bit_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && cfg.res == 2'b11) |=> (dataOut[REG_W-1:6] == '0));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SMP_W     = 3,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfg_t              cfg,
  input  logic [SMP_W-1:0]  nextSmp,
  output ctlStrobe_t        strb,
  output logic [SLOT_W-1:0] slotIdx,
  output logic [SLOT_W-1:0] nextIdx,
  output logic              anaStart
);

  seqState_t         state;
  logic [CNT_W-1:0]  cnt;
  logic              lastSlot;
  logic              phaseEnd;
  logic              wrapOrStop;

  assign lastSlot   = !cfg.scan || (32'(slotIdx) >= 32'(cfg.seqLen));
  assign phaseEnd   = (cnt == '0);
  assign nextIdx    = (state == ST_CONV && !lastSlot) ? slotIdx + 1'b1 : '0;
  assign wrapOrStop = lastSlot && !cfg.continuous;

  assign strb.startAck = (state == ST_IDLE) && cfg.enable && cfg.startReq;
  assign strb.capture  = (state == ST_CONV) && phaseEnd;
  assign strb.busy     = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      slotIdx  <= '0;
      anaStart <= 1'b0;
    end else if (!cfg.enable) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      slotIdx  <= '0;
      anaStart <= 1'b0;
    end else begin
      anaStart <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cfg.startReq) begin
            state    <= ST_SAMPLE;
            slotIdx  <= '0;
            cnt      <= smpCycles(nextSmp) - 1'b1;
            anaStart <= 1'b1;
          end
        end
        ST_SAMPLE: begin
          if (phaseEnd) begin
            state <= ST_CONV;
            cnt   <= convCycles(cfg.res) - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CONV: begin
          if (!phaseEnd) begin
            cnt <= cnt - 1'b1;
          end else if (wrapOrStop) begin
            state   <= ST_IDLE;
            slotIdx <= '0;
          end else begin
            state    <= ST_SAMPLE;
            slotIdx  <= nextIdx;
            cnt      <= smpCycles(nextSmp) - 1'b1;
            anaStart <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: power-down forces the sequencer idle on the next edge
  a_r5_off_idle: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable |=> (state == ST_IDLE));

  // R2: phase counter never exceeds the longest sampling window
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> (cnt < 9'd480));

  // R1: a conversion phase is never entered straight from idle
  a_r1_sample_first: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |=> (state != ST_CONV));

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH    = 19,
  parameter int NUM_SLOTS = 16,
  parameter int CH_W      = 5,
  parameter int SMP_W     = 3,
  parameter int DATA_W    = 12,
  parameter int REG_W     = 16,
  parameter int BUS_W     = 32,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]  regWdata,
  output logic [BUS_W-1:0]  regRdata,
  output logic              anaStart,
  output logic              anaLatch,
  output logic [CH_W-1:0]   anaChan,
  input  logic [DATA_W-1:0] anaValue,
  output logic              eocFlag,
  output logic [REG_W-1:0]  dataOut
);

  localparam int SLOT_W = $clog2(NUM_SLOTS);

  cfg_t              cfg;
  ctlStrobe_t        strb;
  logic [SLOT_W-1:0] slotIdx, nextIdx;
  logic [SMP_W-1:0]  nextSmp;

  adc_seq_regs #(
    .NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS), .CH_W(CH_W), .SMP_W(SMP_W),
    .DATA_W(DATA_W), .REG_W(REG_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
  ) uRegs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .strb(strb), .slotIdx(slotIdx),
    .nextIdx(nextIdx), .anaValue(anaValue), .cfg(cfg), .curChan(anaChan),
    .nextSmp(nextSmp), .eocFlag(eocFlag), .dataOut(dataOut)
  );

  adc_seq_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .SMP_W(SMP_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .nextSmp(nextSmp), .strb(strb),
    .slotIdx(slotIdx), .nextIdx(nextIdx), .anaStart(anaStart)
  );

  assign anaLatch = strb.capture;

endmodule

// File: tb/sim_adc_seq_top.sv
`timescale 1ns/1ps
module sim_adc_seq_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0, regRe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        anaStart, anaLatch, eocFlag;
  logic [4:0]  anaChan;
  logic [11:0] anaValue;
  logic [15:0] dataOut;

  always #2 clk = ~clk;

  function automatic logic [11:0] model(input int ch);
    return 12'(ch * 211 + 100);
  endfunction

  assign anaValue = model(int'(anaChan));

  adc_seq_top u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .anaStart(anaStart),
    .anaLatch(anaLatch), .anaChan(anaChan), .anaValue(anaValue),
    .eocFlag(eocFlag), .dataOut(dataOut)
  );

  int nCmp = 0, nBad = 0;
  int startCnt = 0, latchCnt = 0;
  bit finished = 0;
  logic [15:0] expQ[$];
  bit pend = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  // monitor: result due one edge after the anaLatch cycle
  always @(negedge clk) begin
    if (pend) begin
      nCmp++;
      if (expQ.size() == 0) begin
        nBad++;
        $display("FAIL R8 unexpected result got %0h expected none", dataOut);
      end else begin
        logic [15:0] e;
        e = expQ.pop_front();
        if (dataOut !== e) begin
          nBad++;
          $display("FAIL R8 result got %0h expected %0h", dataOut, e);
        end
      end
      chk("R7 flag after capture", {31'd0, eocFlag}, 32'd1);
    end
    pend = anaLatch;
    if (anaStart) startCnt++;
    if (anaLatch) latchCnt++;
  end

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regRe = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  function automatic logic [31:0] ctrlWord(input bit en, st, cont, scan, input logic [1:0] res);
    return {26'd0, res, scan, cont, st, en};
  endfunction

  function automatic logic [15:0] expect16(input int ch, input logic [1:0] res);
    return 16'(model(ch) >> (2 * res));
  endfunction

  function automatic int smpLen(input int code);
    case (code)
      0: return 3; 1: return 15; 2: return 28; 3: return 56;
      4: return 84; 5: return 112; 6: return 144; default: return 480;
    endcase
  endfunction

  // all channels same code (modeSel=0) or code = ch % 8 (modeSel=1)
  task automatic progSmp(input int code, input bit modeSel);
    logic [31:0] lo, hi;
    lo = '0; hi = '0;
    for (int c = 0; c < 19; c++) begin
      int k;
      k = modeSel ? (c % 8) : code;
      if (c < 10) lo[3*c +: 3] = 3'(k);
      else        hi[3*(c-10) +: 3] = 3'(k);
    end
    busWrite(3'd2, lo);
    busWrite(3'd3, hi);
  endtask

  task automatic progSeq(input int c0, c1, c2, c3, input int len);
    busWrite(3'd4, {12'd0, 5'(c3), 5'(c2), 5'(c1), 5'(c0)});
    busWrite(3'd5, 32'd0);
    busWrite(3'd6, {8'd0, 4'(len), 20'd0});
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    repeat (2) @(negedge clk);
    do busRead(3'd0, s); while (s[1]);
  endtask

  // R1 R2: latency from start write to flag
  task automatic runLatency(input int ch, input int code, input logic [1:0] res);
    int n;
    logic [31:0] d;
    progSmp(code, 0);
    progSeq(ch, 0, 0, 0, 0);
    busWrite(3'd0, 32'd0);
    expQ.push_back(expect16(ch, res));
    busWrite(3'd1, ctrlWord(1, 1, 0, 0, res));
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!eocFlag && n < 1000);
    chk($sformatf("R1 R2 latency res=%0d code=%0d", res, code), n,
        1 + smpLen(code) + (15 - 2 * int'(res)));
    busRead(3'd7, d);
    chk("R8 DATA readback", d, {16'd0, expect16(ch, res)});
    chk("R7 cleared by DATA read", {31'd0, eocFlag}, 32'd0);
    waitIdle();
  endtask

  initial begin
    logic [31:0] d;
    int s0, l0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9 reset state
    busRead(3'd1, d); chk("R9 CTRL reset", d, 0);
    busRead(3'd0, d); chk("R9 STATUS reset", d, 0);
    busRead(3'd7, d); chk("R9 DATA reset", d, 0);
    chk("R7 flag reset", {31'd0, eocFlag}, 0);

    // R5: start while powered down
    progSeq(3, 0, 0, 0, 0);
    busWrite(3'd1, ctrlWord(0, 1, 0, 0, 2'd0));
    repeat (60) @(negedge clk);
    chk("R5 no start while off", startCnt, 0);
    busRead(3'd1, d); chk("R5 start bit not held while off", d, 0);

    runLatency(8, 1, 2'd1);
    runLatency(4, 0, 2'd0);
    runLatency(17, 3, 2'd2);
    runLatency(12, 7, 2'd3);

    // R7 clear by writing 0 to STATUS
    progSmp(0, 0);
    progSeq(5, 0, 0, 0, 0);
    expQ.push_back(expect16(5, 2'd0));
    busWrite(3'd1, ctrlWord(1, 1, 0, 0, 2'd0));
    waitIdle();
    chk("R7 set after conversion", {31'd0, eocFlag}, 1);
    busWrite(3'd0, 32'd0);
    chk("R7 cleared by status write", {31'd0, eocFlag}, 0);

    // R3 scan sequence, 4 slots, mixed sampling codes
    progSmp(0, 1);
    progSeq(3, 18, 0, 7, 3);
    l0 = latchCnt;
    expQ.push_back(expect16(3, 2'd2));
    expQ.push_back(expect16(18, 2'd2));
    expQ.push_back(expect16(0, 2'd2));
    expQ.push_back(expect16(7, 2'd2));
    busWrite(3'd1, ctrlWord(1, 1, 0, 1, 2'd2));
    waitIdle();
    repeat (600) @(negedge clk);
    chk("R3 scan converts four slots", latchCnt - l0, 4);
    chk("R3 queue drained", expQ.size(), 0);

    // R3 scan clear: only slot 0
    progSeq(4, 10, 11, 12, 3);
    l0 = latchCnt;
    expQ.push_back(expect16(4, 2'd0));
    busWrite(3'd1, ctrlWord(1, 1, 0, 0, 2'd0));
    waitIdle();
    repeat (600) @(negedge clk);
    chk("R3 no scan converts one slot", latchCnt - l0, 1);

    // R6 start ignored while busy, bit self-clears
    progSmp(7, 0);
    progSeq(5, 6, 0, 0, 1);
    s0 = startCnt;
    expQ.push_back(expect16(5, 2'd0));
    expQ.push_back(expect16(6, 2'd0));
    busWrite(3'd1, ctrlWord(1, 1, 0, 1, 2'd0));
    repeat (100) @(negedge clk);
    busRead(3'd1, d); chk("R6 start bit self-clears", d[1], 0);
    busRead(3'd0, d); chk("R6 busy while running", d[1], 1);
    busWrite(3'd1, ctrlWord(1, 1, 0, 1, 2'd0));
    waitIdle();
    repeat (1100) @(negedge clk);
    chk("R6 second start ignored", startCnt - s0, 2);

    // R4 continuous, then R5 abort
    progSmp(0, 0);
    progSeq(2, 9, 0, 0, 1);
    l0 = latchCnt;
    for (int i = 0; i < 3; i++) begin
      expQ.push_back(expect16(2, 2'd3));
      expQ.push_back(expect16(9, 2'd3));
    end
    busWrite(3'd1, ctrlWord(1, 1, 1, 1, 2'd3));
    while (expQ.size() != 0) @(negedge clk);
    busWrite(3'd1, ctrlWord(0, 0, 1, 1, 2'd3));
    chk("R4 six results without restart", latchCnt - l0, 6);
    l0 = latchCnt;
    repeat (80) @(negedge clk);
    busRead(3'd0, d); chk("R5 idle after power-down", d[1], 0);
    chk("R5 no result after abort", latchCnt - l0, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nCmp++; nBad++;
      $display("FAIL watchdog expired got running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule